// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer and code register of a successive-approximation analog-to-digital converter. A start pulse loads a trial code whose top bit is set and whose other bits are clear. The trial code drives an external DAC. On every following clock cycle the block reads two comparator flags and settles one bit, working from the most significant bit down to the least. The flags are "input above trial" and "input equal to trial". When all bits are settled, or when the equal flag shows an exact match, the final code is written to a result register and a one-cycle done strobe is raised.

The block has two states. In `ST_IDLE` it waits for `start`. The transition *accept* moves it to `ST_CONV` and loads the first trial code. `ST_CONV` stays in place through the transition *step*, which settles one bit per cycle. It returns to `ST_IDLE` through one of two transitions. *Match* is taken when the equal flag is high, and it freezes the trial code. *Exhaust* is taken when the least significant bit has just been settled. If the equal flag is never raised, every conversion takes the same number of cycles, whatever the input level.

Top module: `sar_ctrl`

## Requirements
- R1: In the cycle after a `start` is accepted in idle, `trial` equals the code with only bit N-1 set, and `busy` is high.
- R2: In `ST_CONV`, when `cmp_gt` is 1 and `cmp_eq` is 0, the bit under test stays 1 and the next lower bit is set to 1 in the next cycle.
- R3: In `ST_CONV`, when both `cmp_gt` and `cmp_eq` are 0, the bit under test is cleared and the next lower bit is set to 1 in the next cycle.
- R4: Bits are settled one per cycle from bit N-1 down to bit 0. Without a match, `done` rises exactly N clock edges after the accepting edge.
- R5: When `cmp_eq` is 1 in `ST_CONV`, the conversion ends on that edge. `result` takes the current trial code and `trial` keeps its value.
- R6: `busy` is high from the accepting edge until the edge that raises `done`. `done` and `busy` are never high together.
- R7: A `start` that arrives while `busy` is high is ignored. The conversion's codes, length and result are unchanged.
- R8: `done` lasts exactly one cycle. `result` changes only on the edge that raises `done`, and `trial` holds its value while idle.
- R9: Synchronous active-high `rst` returns the block to idle with `trial` and `result` at 0 and `busy` and `done` low, also in the middle of a conversion.
- R10: While idle and without `start`, the comparator inputs have no effect on `trial`, `result`, `busy` or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a conversion when the block is idle |
| cmp_gt | input | 1 | Comparator: the analog input is above the trial code |
| cmp_eq | input | 1 | Comparator: the analog input equals the trial code |
| trial | output | N | Trial code driven to the external DAC |
| result | output | N | Final code of the last finished conversion |
| busy | output | 1 | High while a conversion is running |
| done | output | 1 | One-cycle strobe when a conversion finishes |

## Verification
Every input level of an 8-bit configuration is converted twice.

- **With the equal flag active:** the result must reproduce the level exactly. The length of the conversion must be N minus the number of trailing zero bits of the level. This separates early stopping from running through all bits.
- **With the equal flag forced low:** every conversion must take exactly N cycles. The result must be one below the level, which confirms that an exact match on its own clears the bit under test.

For both runs, the expected trial code is computed at every cycle from the prefix of the target value. This catches a wrong bit order or a wrong keep or clear decision at the cycle where it happens.

Further runs cover:
- start pulses sent in the middle of a conversion;
- comparator activity while the block is idle;
- a reset applied halfway through a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } sar_state_t;
endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cmp_eq,
    input  logic last_bit,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy,
    output logic done
);
    sar_state_t state_q, state_d;
    logic       done_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin          // accept
                    load    = 1'b1;
                    state_d = ST_CONV;
                end
            end
            ST_CONV: begin
                step = 1'b1;              // step
                if (cmp_eq || last_bit) begin  // match / exhaust
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q == ST_CONV);
    assign done = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                   // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                   // R6
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         finish,
    input  logic         cmp_gt,
    input  logic         cmp_eq,
    output logic [N-1:0] trial,
    output logic [N-1:0] result,
    output logic         last_bit
);
    localparam logic [N-1:0] TOP_CODE = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] trial_q, probe_q, result_q, trial_nx;

    // per-bit next trial: settle the probed bit, arm the one below it
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == N-1) begin : g_top
            assign trial_nx[i] = probe_q[i] ? cmp_gt : trial_q[i];
        end else begin : g_low
            assign trial_nx[i] = probe_q[i]   ? cmp_gt :
                                 probe_q[i+1] ? 1'b1   : trial_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q  <= '0;
            probe_q  <= '0;
            result_q <= '0;
        end else if (load) begin
            trial_q <= TOP_CODE;
            probe_q <= TOP_CODE;
        end else if (step) begin
            if (cmp_eq) begin
                result_q <= trial_q;
            end else begin
                trial_q <= trial_nx;
                probe_q <= probe_q >> 1;
                if (finish) result_q <= trial_nx;
            end
        end
    end

    assign trial    = trial_q;
    assign result   = result_q;
    assign last_bit = probe_q[0];

    AST_PROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        step |-> $onehot(probe_q));                        // R4
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         cmp_gt,
    input  logic         cmp_eq,
    output logic [N-1:0] trial,
    output logic [N-1:0] result,
    output logic         busy,
    output logic         done
);
    localparam logic [N-1:0] TOP_CODE = {1'b1, {(N-1){1'b0}}};

    logic load, step, finish, last_bit;

    sar_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmp_eq   (cmp_eq),
        .last_bit (last_bit),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .busy     (busy),
        .done     (done)
    );

    sar_datapath #(.N(N)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .cmp_gt   (cmp_gt),
        .cmp_eq   (cmp_eq),
        .trial    (trial),
        .result   (result),
        .last_bit (last_bit)
    );

    // one cycle after reset release, history is valid
    logic hist_ok;
    always_ff @(posedge clk) begin
        if (rst) hist_ok <= 1'b0;
        else     hist_ok <= 1'b1;
    end

    AST_START_CODE: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && trial == TOP_CODE)); // R1
    AST_EQ_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (busy && cmp_eq) |=> (done && $stable(trial)));    // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && !done) |-> $stable(result));           // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && !busy && !start) |=> ($stable(trial) && !busy)); // R10
endmodule

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;
    localparam int N = 8;
    localparam int MAXV = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         eq_en = 1'b1;
    logic [N-1:0] level = '0;
    logic         cmp_gt, cmp_eq;
    logic [N-1:0] trial, result;
    logic         busy, done;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // comparator model: integer compare against the stimulus level
    assign cmp_gt = (level > trial);
    assign cmp_eq = eq_en && (level == trial);

    sar_ctrl #(.N(N)) u_sar_ctrl (
        .clk(clk), .rst(rst), .start(start), .cmp_gt(cmp_gt), .cmp_eq(cmp_eq),
        .trial(trial), .result(result), .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tz(input int v);
        int n = 0;
        while (n < N && ((v >> n) & 1) == 0) n++;
        return n;
    endfunction

    // trial code expected before decision k (1..N) when converging to target
    function automatic int exp_trial(input int target, input int k);
        int bitpos = N - k;
        int upper  = target & ~((1 << (bitpos + 1)) - 1);
        return (upper | (1 << bitpos)) & MAXV;
    endfunction

    task automatic convert(input int v, input logic use_eq, input logic poke);
        int target, exp_dec, k;
        logic [N-1:0] res_before;
        target  = use_eq ? v : ((v > 0) ? v - 1 : 0);
        exp_dec = (use_eq && v != 0) ? N - tz(v) : N;
        @(negedge clk);
        level = v[N-1:0];
        eq_en = use_eq;
        start = 1'b1;
        res_before = result;
        @(negedge clk);
        start = 1'b0;
        check("R1 first trial", trial == (1 << (N-1)), trial, 1 << (N-1));
        k = 1;
        forever begin
            check("R2/R3 trial code", trial == exp_trial(target, k), trial, exp_trial(target, k));
            check("R6 busy during conversion", busy && !done, {busy, done}, 2);
            if (k < exp_dec)
                check("R8 result held mid-conversion", result == res_before, result, res_before);
            if (poke && k == 2) start = 1'b1;   // R7 stray start
            @(negedge clk);
            start = 1'b0;
            if (done || k > N + 1) break;
            k++;
        end
        check(use_eq ? "R5 decision count" : "R4 decision count", k == exp_dec, k, exp_dec);
        check(use_eq ? "R5 result" : "R4 result", result == target, result, target);
        check("R6 busy low with done", !busy, busy, 0);
        if (use_eq && v != 0)
            check("R5 trial frozen", trial == target, trial, target);
        @(negedge clk);
        check("R8 done one cycle", !done, done, 0);
        check("R8 result held", result == target, result, target);
        check("R7 no restart after stray start", !busy, busy, 0);
    endtask

    initial begin
        #200000000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] t_hold;
        repeat (3) @(negedge clk);
        check("R9 reset trial", trial == 0, trial, 0);
        check("R9 reset result", result == 0, result, 0);
        check("R9 reset busy/done", !busy && !done, {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R10: comparator activity while idle
        t_hold = trial;
        for (int i = 0; i < 8; i++) begin
            level = 8'(i * 37);
            @(negedge clk);
            check("R10 idle trial unchanged", trial == t_hold, trial, t_hold);
            check("R10 idle no busy/done", !busy && !done, {busy, done}, 0);
        end

        // exhaustive sweep with early stop
        for (int v = 0; v <= MAXV; v++) convert(v, 1'b1, 1'b0);
        // exhaustive sweep with the equal flag forced low
        for (int v = 0; v <= MAXV; v++) convert(v, 1'b0, 1'b0);
        // R7: stray starts during conversion
        convert(8'hA5, 1'b1, 1'b1);
        convert(8'h01, 1'b0, 1'b1);
        convert(8'hFF, 1'b1, 1'b1);

        // R10: after a finished conversion, trial holds while idle
        t_hold = trial;
        level = 8'h3C;
        repeat (4) @(negedge clk);
        check("R8 trial holds when idle", trial == t_hold, trial, t_hold);

        // R9: reset in the middle of a conversion
        level = 8'h77;
        eq_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 mid reset trial", trial == 0, trial, 0);
        check("R9 mid reset result", result == 0, result, 0);
        check("R9 mid reset idle", !busy && !done, {busy, done}, 0);
        @(negedge clk);
        check("R9 stays idle after reset", !busy, busy, 0);
        convert(8'h77, 1'b1, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule